// File: doc/BRIEF.md
# Prefix-Aware Operand Address Generator

This block sits in the decode stage of an 8-bit accumulator machine. It watches the stream of instruction bytes and remembers whether the last accepted byte was one of the two index-prefix codes. It then interprets the register fields of the next opcode in light of that prefix.

Three things come out of that decode. The first is the pair of 3-bit register selects taken from the opcode. The second is a flag saying whether either select names memory. The third is the 16-bit effective address of that memory operand. Without a prefix the address is the HL register. Under an index prefix it is the chosen index register plus the sign-extended displacement byte. Under a prefix the 2-bit register-pair field also redirects its HL slot to the index register.

The decode outputs are combinational from the current byte and the latched prefix. The prefix state updates on the clock edge that accepts the byte.

Top module: `opa_addr_gen`

## Requirements
- R1: After reset (rst_ni low), prefix_o reads 0 (none).
- R2: An accepted byte (byte_valid_i high) of 0xDD sets prefix_o to 1 (IX) on the next cycle, and an accepted 0xFD sets it to 2 (IY).
- R3: When prefix bytes arrive back to back, prefix_o follows only the most recent one.
- R4: An accepted byte that is not a prefix clears prefix_o to 0 on the next cycle. While byte_valid_i is low, prefix_o keeps its value.
- R5: src_reg_o carries opcode bits [2:0] and dst_reg_o carries bits [5:3]. Register codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7. Code 6 marks a memory operand and raises src_mem_o or dst_mem_o respectively.
- R6: mem_op_o is high exactly when decode_valid_o is high and at least one of the two fields holds code 6.
- R7: With prefix_o at 0, ea_o equals hl_i.
- R8: With prefix_o at 1 or 2, ea_o equals ix_i or iy_i respectively, plus disp_i taken as a signed byte (-128..127) sign-extended to 16 bits. The sum wraps modulo 65536.
- R9: pair_sel_o decodes opcode bits [5:4]. Field 00 gives 0 (BC) and field 01 gives 1 (DE). Field 10 gives 2 (HL) with no prefix, 4 (IX) under prefix 1 and 5 (IY) under prefix 2. Field 11 gives 3 (SP). pair_val_o gives the value of the selected HL, IX, IY or SP register, and 0 for BC and DE.
- R10: decode_valid_o is high when byte_valid_i is high and opcode_i is neither 0xDD nor 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | opcode_i holds an accepted instruction byte |
| opcode_i | input | 8 | Instruction byte |
| disp_i | input | 8 | Signed displacement byte |
| hl_i | input | 16 | Current HL value |
| ix_i | input | 16 | Current IX value |
| iy_i | input | 16 | Current IY value |
| sp_i | input | 16 | Current SP value |
| decode_valid_o | output | 1 | A non-prefix opcode is being decoded |
| prefix_o | output | 2 | Latched prefix: 0 none, 1 IX, 2 IY |
| dst_reg_o | output | 3 | Destination register code |
| dst_mem_o | output | 1 | Destination field names memory |
| src_reg_o | output | 3 | Source register code |
| src_mem_o | output | 1 | Source field names memory |
| mem_op_o | output | 1 | Decoded opcode has a memory operand |
| pair_sel_o | output | 3 | Register-pair select |
| pair_val_o | output | 16 | Value of the selected pair |
| ea_o | output | 16 | Memory operand effective address |

## Verification
The assertions check the prefix transitions on every cycle: set, override, clear and hold. They also check the offset relation between ea_o and the active index register, and that the memory flag and the HL pair code never appear in a state that forbids them.

Three behaviours can only be shown by the bench's directed sequences. These are the exact wrap of a negative or large displacement across zero, the per-field decode of concrete opcodes, and the prefix surviving idle gaps before it is consumed.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int FIELD_W = 3;

  localparam logic [BYTE_W-1:0] OP_PFX_IX = 8'hDD;
  localparam logic [BYTE_W-1:0] OP_PFX_IY = 8'hFD;
  localparam logic [FIELD_W-1:0] CODE_MEM = 3'b110;

  typedef enum logic [1:0] {
    PFX_NONE = 2'd0,
    PFX_IX   = 2'd1,
    PFX_IY   = 2'd2
  } pfx_e;

  typedef enum logic [2:0] {
    PAIR_BC = 3'd0,
    PAIR_DE = 3'd1,
    PAIR_HL = 3'd2,
    PAIR_SP = 3'd3,
    PAIR_IX = 3'd4,
    PAIR_IY = 3'd5
  } pair_e;
endpackage

// File: rtl/opa_prefix_track.sv
module opa_prefix_track
  import opa_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [BW-1:0] byte_i,
  output logic          is_prefix_o,
  output pfx_e          prefix_o
);
  pfx_e prefix_q, prefix_d;

  assign is_prefix_o = (byte_i == OP_PFX_IX) || (byte_i == OP_PFX_IY);

  always_comb begin
    prefix_d = prefix_q;
    if (valid_i) begin
      if (byte_i == OP_PFX_IX)      prefix_d = PFX_IX;
      else if (byte_i == OP_PFX_IY) prefix_d = PFX_IY;
      else                          prefix_d = PFX_NONE; // consumed by this opcode
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prefix_q <= PFX_NONE;
    else         prefix_q <= prefix_d;
  end

  assign prefix_o = prefix_q;

  a_r2_dd_sets_ix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && byte_i == OP_PFX_IX) |=> (prefix_o == PFX_IX));
  a_r3_fd_sets_iy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && byte_i == OP_PFX_IY) |=> (prefix_o == PFX_IY));
  a_r4_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && byte_i != OP_PFX_IX && byte_i != OP_PFX_IY) |=> (prefix_o == PFX_NONE));
  a_r4_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prefix_o));
endmodule

// File: rtl/opa_reg_field.sv
module opa_reg_field
  import opa_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic [FW-1:0] code_i,
  output logic [FW-1:0] reg_o,
  output logic          mem_o
);
  assign reg_o = code_i;
  assign mem_o = (code_i == CODE_MEM);
endmodule

// File: rtl/opa_ea_calc.sv
module opa_ea_calc
  import opa_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  pfx_e          prefix_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [BW-1:0] disp_i,
  output logic [AW-1:0] ea_o
);
  localparam int EXT_W = AW - BW;

  logic [AW-1:0] base, offs;

  always_comb begin
    unique case (prefix_i)
      PFX_IX:  begin base = ix_i; offs = {{EXT_W{disp_i[BW-1]}}, disp_i}; end
      PFX_IY:  begin base = iy_i; offs = {{EXT_W{disp_i[BW-1]}}, disp_i}; end
      default: begin base = hl_i; offs = '0; end
    endcase
  end

  assign ea_o = base + offs; // wraps at 2^AW
endmodule

// File: rtl/opa_addr_gen.sv
module opa_addr_gen
  import opa_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [BW-1:0] opcode_i,
  input  logic [BW-1:0] disp_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  input  logic [AW-1:0] sp_i,
  output logic          decode_valid_o,
  output logic [1:0]    prefix_o,
  output logic [2:0]    dst_reg_o,
  output logic          dst_mem_o,
  output logic [2:0]    src_reg_o,
  output logic          src_mem_o,
  output logic          mem_op_o,
  output logic [2:0]    pair_sel_o,
  output logic [AW-1:0] pair_val_o,
  output logic [AW-1:0] ea_o
);
  localparam int NFIELD = 2; // 0: source, 1: destination
  localparam int EXT_W  = AW - BW;

  pfx_e              prefix;
  logic              is_prefix;
  logic [FIELD_W-1:0] fld_code [NFIELD];
  logic [FIELD_W-1:0] fld_reg  [NFIELD];
  logic [NFIELD-1:0]  fld_mem;
  pair_e             pair_sel;

  opa_prefix_track #(.BW(BW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (byte_valid_i),
    .byte_i      (opcode_i),
    .is_prefix_o (is_prefix),
    .prefix_o    (prefix)
  );

  assign fld_code[0] = opcode_i[2:0];
  assign fld_code[1] = opcode_i[5:3];

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    opa_reg_field #(.FW(FIELD_W)) u_field (
      .code_i (fld_code[g]),
      .reg_o  (fld_reg[g]),
      .mem_o  (fld_mem[g])
    );
  end

  opa_ea_calc #(.AW(AW), .BW(BW)) u_ea (
    .prefix_i (prefix),
    .hl_i     (hl_i),
    .ix_i     (ix_i),
    .iy_i     (iy_i),
    .disp_i   (disp_i),
    .ea_o     (ea_o)
  );

  always_comb begin
    pair_val_o = '0;
    unique case (opcode_i[5:4])
      2'b00: pair_sel = PAIR_BC;
      2'b01: pair_sel = PAIR_DE;
      2'b10: begin
        unique case (prefix)
          PFX_IX:  begin pair_sel = PAIR_IX; pair_val_o = ix_i; end
          PFX_IY:  begin pair_sel = PAIR_IY; pair_val_o = iy_i; end
          default: begin pair_sel = PAIR_HL; pair_val_o = hl_i; end
        endcase
      end
      default: begin pair_sel = PAIR_SP; pair_val_o = sp_i; end
    endcase
  end

  assign decode_valid_o = byte_valid_i && !is_prefix;
  assign src_reg_o      = fld_reg[0];
  assign dst_reg_o      = fld_reg[1];
  assign src_mem_o      = fld_mem[0];
  assign dst_mem_o      = fld_mem[1];
  assign mem_op_o       = decode_valid_o && (|fld_mem);
  assign prefix_o       = prefix;
  assign pair_sel_o     = pair_sel;

  a_r1_reset_none: assert property (@(posedge clk_i)
    !rst_ni |=> (prefix_o == PFX_NONE) || rst_ni);
  a_r6_mem_needs_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_op_o |-> decode_valid_o);
  a_r7_plain_hl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_o == PFX_NONE) |-> (ea_o == hl_i));
  a_r8_ix_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_o == PFX_IX) |-> (AW'(ea_o - ix_i) == {{EXT_W{disp_i[BW-1]}}, disp_i}));
  a_r8_iy_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_o == PFX_IY) |-> (AW'(ea_o - iy_i) == {{EXT_W{disp_i[BW-1]}}, disp_i}));
  a_r9_hl_only_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_sel_o == PAIR_HL) |-> (prefix_o == PFX_NONE));
  a_r10_decode_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_valid_o |-> byte_valid_i);
endmodule

// File: tb/opa_addr_gen_bench.sv
module opa_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] hl_i = 16'h1234, ix_i = 16'h2000, iy_i = 16'h3000, sp_i = 16'hFFF0;
  logic        decode_valid_o, dst_mem_o, src_mem_o, mem_op_o;
  logic [1:0]  prefix_o;
  logic [2:0]  dst_reg_o, src_reg_o, pair_sel_o;
  logic [15:0] pair_val_o, ea_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opa_addr_gen u_opa_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .opcode_i(opcode_i),
    .disp_i(disp_i), .hl_i(hl_i), .ix_i(ix_i), .iy_i(iy_i), .sp_i(sp_i),
    .decode_valid_o(decode_valid_o), .prefix_o(prefix_o), .dst_reg_o(dst_reg_o),
    .dst_mem_o(dst_mem_o), .src_reg_o(src_reg_o), .src_mem_o(src_mem_o),
    .mem_op_o(mem_op_o), .pair_sel_o(pair_sel_o), .pair_val_o(pair_val_o), .ea_o(ea_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive after the falling edge, settle, then sample
  task automatic step(bit v, logic [7:0] op, logic [7:0] d = 8'h00);
    @(negedge clk);
    byte_valid_i = v; opcode_i = op; disp_i = d;
    #2;
  endtask

  function automatic int ea_of(int base, int d);
    int s = (d >= 128) ? d - 256 : d;
    return (base + s + 65536) % 65536;
  endfunction

  task automatic t_reset();
    step(0, 8'h00);
    chk("R1 prefix after reset", prefix_o, 0);
    chk("R10 idle decode_valid", decode_valid_o, 0);
    chk("R6 idle mem_op", mem_op_o, 0);
  endtask

  task automatic t_plain();
    step(1, 8'h7E);
    chk("R5 dst code", dst_reg_o, 7);
    chk("R5 src code", src_reg_o, 6);
    chk("R5 src mem", src_mem_o, 1);
    chk("R5 dst mem", dst_mem_o, 0);
    chk("R6 mem_op", mem_op_o, 1);
    chk("R7 ea is hl", ea_o, 16'h1234);
    chk("R10 decode_valid", decode_valid_o, 1);
    step(1, 8'h41);
    chk("R5 dst B", dst_reg_o, 0);
    chk("R5 src C", src_reg_o, 1);
    chk("R6 no mem", mem_op_o, 0);
    chk("R4 stays none", prefix_o, 0);
    step(1, 8'h21);
    chk("R9 pair HL", pair_sel_o, 2);
    chk("R9 pair HL val", pair_val_o, 16'h1234);
    step(1, 8'h31);
    chk("R9 pair SP", pair_sel_o, 3);
    chk("R9 pair SP val", pair_val_o, 16'hFFF0);
    step(1, 8'h11);
    chk("R9 pair DE", pair_sel_o, 1);
    chk("R9 pair DE val", pair_val_o, 0);
  endtask

  task automatic t_ix();
    step(1, 8'hDD);
    chk("R10 prefix byte not decoded", decode_valid_o, 0);
    chk("R6 prefix byte no mem_op", mem_op_o, 0);
    step(1, 8'h7E, 8'h05);
    chk("R2 prefix IX", prefix_o, 1);
    chk("R8 ea ix+5", ea_o, ea_of(16'h2000, 5));
    chk("R6 mem_op under IX", mem_op_o, 1);
    step(1, 8'h21);
    chk("R4 cleared after use", prefix_o, 0);
    chk("R9 pair back to HL", pair_sel_o, 2);
    step(1, 8'hDD);
    step(1, 8'h21);
    chk("R9 pair IX", pair_sel_o, 4);
    chk("R9 pair IX val", pair_val_o, 16'h2000);
  endtask

  task automatic t_iy_wrap();
    iy_i = 16'h0010;
    step(1, 8'hFD);
    step(1, 8'h86, 8'h80);
    chk("R2 prefix IY", prefix_o, 2);
    chk("R8 negative wrap", ea_o, 16'hFF90);
    iy_i = 16'hFFF0;
    step(1, 8'hFD);
    step(1, 8'h46, 8'h7F);
    chk("R8 positive wrap", ea_o, ea_of(16'hFFF0, 8'h7F));
    chk("R5 src mem under IY", src_mem_o, 1);
    chk("R5 dst B under IY", dst_reg_o, 0);
  endtask

  task automatic t_double();
    step(1, 8'hDD);
    step(1, 8'hFD);
    step(1, 8'h21);
    chk("R3 later FD wins", prefix_o, 2);
    chk("R3 pair IY", pair_sel_o, 5);
    chk("R9 pair IY val", pair_val_o, 16'hFFF0);
    step(1, 8'hFD);
    step(1, 8'hDD);
    step(1, 8'h7E, 8'hFE);
    chk("R3 later DD wins", prefix_o, 1);
    chk("R3 ea ix-2", ea_o, 16'h1FFE);
  endtask

  task automatic t_idle();
    step(1, 8'hDD);
    for (int i = 0; i < 3; i++) begin
      step(0, 8'h55);
      chk("R4 held while idle", prefix_o, 1);
      chk("R10 idle no decode", decode_valid_o, 0);
    end
    step(1, 8'h70, 8'h10);
    chk("R5 dst mem", dst_mem_o, 1);
    chk("R5 dst code 6", dst_reg_o, 6);
    chk("R8 ea ix+16", ea_o, 16'h2010);
    step(0, 8'h00);
    chk("R4 cleared after store", prefix_o, 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_plain();
    t_ix();
    t_iy_wrap();
    t_double();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule